// File: doc/BRIEF.md
# Receive Elastic Store with Frame Slip Control

This block is a two-frame elastic buffer between a recovered line clock and a system highway clock. The line side writes one byte per enabled write clock and marks the first byte of each frame. The highway side pulls one byte per enabled read clock and receives a frame-start marker with the first byte of each frame it reads. Small phase wander between the two clocks is absorbed by the buffer's slack. Lasting frequency offset would make the two pointers meet, so the block performs a controlled slip.

A slip is decided only when the reader is about to begin a new frame. At that point the reader compares its pointer with a synchronised copy of the write pointer. That copy crosses domains in Gray code through two flops. If the writer is too far ahead (the line frame is shorter than the system frame), the reader skips one whole frame and sets the negative-slip flag. If the writer is too close behind (the line frame is longer), the reader repeats the frame it has just delivered and sets the positive-slip flag. Both flags are sticky until a clear strobe in the read domain. FRAME_LEN must be a power of two.

Top module: `rx_elastic_store`

## Requirements
- R1: After reset the read pointer is at byte 0 of slot 0 and the write pointer is one frame ahead, at byte 0 of slot 1. `rd_data_o`, `rd_sof_o` and both slip flags are 0. The first frame written is delivered as the second frame read.
- R2: Each byte read sits at the same position within its frame as the position at which it was written.
- R3: `rd_sof_o` is 1 in the cycle after a read exactly when that read was at frame offset 0, counting FRAME_LEN reads per frame from reset.
- R4: While both sides move bytes at the same rate, consecutive read frames carry consecutive written frames and no slip occurs.
- R5: If at a read frame start the writer leads by more than 3*FRAME_LEN/2 bytes, one whole frame is skipped (the frame read is two after the previous one) and `slip_n_o` is 1 in the following cycle.
- R6: If at a read frame start the writer leads by less than FRAME_LEN/2 bytes, the previous frame is read again and `slip_p_o` is 1 in the following cycle.
- R7: A set slip flag stays at 1 until `slip_clr_i` is sampled high, and the next cycle it is 0 unless a new slip of that kind is taken.
- R8: A slip taken in the same cycle as `slip_clr_i` leaves its flag at 1.
- R9: A write frame start arriving at a nonzero offset moves writing to byte 0 of the next slot. Later frames are then read with their byte positions intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Recovered line clock, write domain |
| rd_clk_i | input | 1 | System highway clock, read domain |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_en_i | input | 1 | Write one byte this write clock |
| wr_sof_i | input | 1 | Current write byte is the first of a frame |
| wr_data_i | input | DATA_W | Write byte |
| rd_en_i | input | 1 | Read one byte this read clock |
| slip_clr_i | input | 1 | Clear strobe for both slip flags, read domain |
| rd_data_o | output | DATA_W | Read byte, valid the cycle after a read |
| rd_sof_o | output | 1 | Read byte is the first of a frame |
| slip_n_o | output | 1 | Sticky flag: a frame was skipped (overflow) |
| slip_p_o | output | 1 | Sticky flag: a frame was repeated (underflow) |

## Verification
A slip decision and the flag clear can land on the same read clock. The bench holds the clear strobe high through whole phases in which the read clock runs slower, and then faster, than the write clock. In those phases every slip meets an active clear, and the flag must still show for exactly that one cycle. Each written byte carries its frame number and offset. The bench therefore judges every slip from the frame-number step seen at each read frame start: a step of two must coincide with the negative flag and a step of zero with the positive flag. A behavioural flag model checks the result on every read clock.

// File: rtl/es_pkg.sv
package es_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_DROP   = 2'd1,
    SLIP_REPEAT = 2'd2
  } slip_act_e;
endpackage

// File: rtl/es_sync.sv
module es_sync #(
  parameter int unsigned    W       = 7,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/es_mem.sv
module es_mem #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              wr_clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/es_wr_side.sv
module es_wr_side #(
  parameter int unsigned FRAME_LEN = 32,
  localparam int unsigned OW = $clog2(FRAME_LEN),
  localparam int unsigned AW = OW + 1,
  localparam int unsigned PW = AW + 1,
  localparam int unsigned FW = PW - OW
) (
  input  logic          wr_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sof_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wptr_gray_o
);
  localparam logic [PW-1:0] PTR_RST  = PW'(FRAME_LEN);
  localparam logic [PW-1:0] GRAY_RST = PTR_RST ^ (PTR_RST >> 1);

  logic [PW-1:0] ptr_q, ptr_d, addr;
  logic [PW-1:0] gray_q;
  logic [OW-1:0] off;

  assign off = ptr_q[OW-1:0];

  // Frame start at a nonzero offset: realign to byte 0 of the next slot
  always_comb begin
    if (wr_sof_i && (off != '0)) addr = {ptr_q[PW-1:OW] + FW'(1), {OW{1'b0}}};
    else                         addr = ptr_q;
    ptr_d = wr_en_i ? addr + PW'(1) : ptr_q;
  end

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= PTR_RST;
      gray_q <= GRAY_RST;
    end else begin
      ptr_q  <= ptr_d;
      gray_q <= ptr_d ^ (ptr_d >> 1);
    end
  end

  assign we_o        = wr_en_i;
  assign waddr_o     = addr[AW-1:0];
  assign wptr_gray_o = gray_q;
endmodule

// File: rtl/es_rd_side.sv
module es_rd_side
  import es_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 32,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned OW = $clog2(FRAME_LEN),
  localparam int unsigned AW = OW + 1,
  localparam int unsigned PW = AW + 1
) (
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              slip_clr_i,
  input  logic [PW-1:0]     wptr_gray_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [AW-1:0]     raddr_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_sof_o,
  output logic              slip_n_o,
  output logic              slip_p_o,
  output logic              drop_o,
  output logic              repeat_o
);
  localparam logic signed [PW-1:0] LO_MARGIN = PW'(FRAME_LEN / 2);
  localparam logic signed [PW-1:0] HI_MARGIN = PW'((3 * FRAME_LEN) / 2);

  logic [PW-1:0]     ptr_q, wbin, addr;
  logic signed [PW-1:0] lead;
  logic [OW-1:0]     off;
  slip_act_e         act;
  logic [DATA_W-1:0] data_q;
  logic              sof_q, slip_n_q, slip_p_q;

  always_comb begin
    wbin[PW-1] = wptr_gray_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wptr_gray_i[i];
  end

  assign off  = ptr_q[OW-1:0];
  assign lead = $signed(wbin - ptr_q);

  always_comb begin
    act = SLIP_NONE;
    if (off == '0) begin
      if (lead < LO_MARGIN)      act = SLIP_REPEAT;
      else if (lead > HI_MARGIN) act = SLIP_DROP;
    end
    unique case (act)
      SLIP_DROP:   addr = ptr_q + PW'(FRAME_LEN);
      SLIP_REPEAT: addr = ptr_q - PW'(FRAME_LEN);
      default:     addr = ptr_q;
    endcase
  end

  assign drop_o   = rd_en_i && (act == SLIP_DROP);
  assign repeat_o = rd_en_i && (act == SLIP_REPEAT);

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      data_q   <= '0;
      sof_q    <= 1'b0;
      slip_n_q <= 1'b0;
      slip_p_q <= 1'b0;
    end else begin
      if (rd_en_i) begin
        ptr_q  <= addr + PW'(1);
        data_q <= mem_rdata_i;
        sof_q  <= (off == '0);
      end else begin
        sof_q  <= 1'b0;
      end
      // new slip wins over clear
      slip_n_q <= drop_o   | (slip_n_q & ~slip_clr_i);
      slip_p_q <= repeat_o | (slip_p_q & ~slip_clr_i);
    end
  end

  assign raddr_o   = addr[AW-1:0];
  assign rd_data_o = data_q;
  assign rd_sof_o  = sof_q;
  assign slip_n_o  = slip_n_q;
  assign slip_p_o  = slip_p_q;
endmodule

// File: rtl/rx_elastic_store.sv
module rx_elastic_store #(
  parameter int unsigned FRAME_LEN = 32,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sof_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              slip_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_sof_o,
  output logic              slip_n_o,
  output logic              slip_p_o
);
  localparam int unsigned OW    = $clog2(FRAME_LEN);
  localparam int unsigned AW    = OW + 1;
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 2 * FRAME_LEN;
  localparam logic [PW-1:0] WPTR_RST  = PW'(FRAME_LEN);
  localparam logic [PW-1:0] WGRAY_RST = WPTR_RST ^ (WPTR_RST >> 1);

  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, wgray_sync;
  logic [DATA_W-1:0] rdata;
  logic              drop_evt, repeat_evt;

  es_wr_side #(.FRAME_LEN(FRAME_LEN)) u_wr (
    .wr_clk_i    (wr_clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sof_i    (wr_sof_i),
    .we_o        (we),
    .waddr_o     (waddr),
    .wptr_gray_o (wgray)
  );

  es_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .wr_clk_i (wr_clk_i),
    .we_i     (we),
    .waddr_i  (waddr),
    .wdata_i  (wr_data_i),
    .raddr_i  (raddr),
    .rdata_o  (rdata)
  );

  es_sync #(.W(PW), .RST_VAL(WGRAY_RST)) u_wsync (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_sync)
  );

  es_rd_side #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W)) u_rd (
    .rd_clk_i    (rd_clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .slip_clr_i  (slip_clr_i),
    .wptr_gray_i (wgray_sync),
    .mem_rdata_i (rdata),
    .raddr_o     (raddr),
    .rd_data_o   (rd_data_o),
    .rd_sof_o    (rd_sof_o),
    .slip_n_o    (slip_n_o),
    .slip_p_o    (slip_p_o),
    .drop_o      (drop_evt),
    .repeat_o    (repeat_evt)
  );
endmodule

// File: rtl/es_checker.sv
module es_checker #(
  parameter int unsigned FRAME_LEN = 32
) (
  input logic rd_clk_i,
  input logic rst_ni,
  input logic rd_en_i,
  input logic slip_clr_i,
  input logic rd_sof_o,
  input logic slip_n_o,
  input logic slip_p_o,
  input logic drop_evt,
  input logic repeat_evt
);
  localparam int unsigned CW = $clog2(FRAME_LEN);
  logic [CW-1:0] rd_cnt_q;

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_cnt_q <= '0;
    else if (rd_en_i) rd_cnt_q <= rd_cnt_q + CW'(1);
  end

  assert_sof_on_frame_start_R3: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_sof_o == ($past(rd_cnt_q) == '0)));

  assert_drop_at_boundary_R5: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $rose(slip_n_o) |-> (rd_sof_o && $past(rd_en_i)));

  assert_repeat_at_boundary_R6: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $rose(slip_p_o) |-> (rd_sof_o && $past(rd_en_i)));

  assert_no_dual_slip_R5: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !(drop_evt && repeat_evt));

  assert_n_sticky_R7: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (slip_n_o && !slip_clr_i) |=> slip_n_o);

  assert_p_sticky_R7: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (slip_p_o && !slip_clr_i) |=> slip_p_o);

  assert_n_set_wins_R8: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    drop_evt |=> slip_n_o);

  assert_p_set_wins_R8: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    repeat_evt |=> slip_p_o);
endmodule

bind rx_elastic_store es_checker #(.FRAME_LEN(FRAME_LEN)) u_es_chk (
  .rd_clk_i   (rd_clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .slip_clr_i (slip_clr_i),
  .rd_sof_o   (rd_sof_o),
  .slip_n_o   (slip_n_o),
  .slip_p_o   (slip_p_o),
  .drop_evt   (drop_evt),
  .repeat_evt (repeat_evt)
);

// File: tb/rx_elastic_store_test.sv
`timescale 1ns/1ps
module rx_elastic_store_test;
  localparam int WR_PERIOD = 10;
  localparam int FL        = 32;
  localparam int FRAMES    = 80;
  localparam int TRUNC_ID  = 6;
  localparam int TRUNC_AT  = 20;

  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en = 1'b0, wr_sof = 1'b0, rd_en = 1'b0, clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_sof, slip_n, slip_p;
  real        rd_half = 5.0;
  bit         done = 1'b0;
  int         tests = 0, fails = 0;

  rx_elastic_store #(.FRAME_LEN(FL), .DATA_W(8)) uut (
    .wr_clk_i   (wr_clk),
    .rd_clk_i   (rd_clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_sof_i   (wr_sof),
    .wr_data_i  (wr_data),
    .rd_en_i    (rd_en),
    .slip_clr_i (clr),
    .rd_data_o  (rd_data),
    .rd_sof_o   (rd_sof),
    .slip_n_o   (slip_n),
    .slip_p_o   (slip_p)
  );

  initial forever #(WR_PERIOD / 2) wr_clk = ~wr_clk;
  initial forever #(rd_half) rd_clk = ~rd_clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Writer: byte = {frame number mod 8, offset}; write frame TRUNC_ID is cut short (R9)
  initial begin
    int wid = 0, widx = 0;
    @(posedge rst_ni);
    while (!done) begin
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_sof  = (widx == 0);
      wr_data = {3'(wid), 5'(widx)};
      widx++;
      if (widx == FL || (wid == TRUNC_ID && widx == TRUNC_AT)) begin
        widx = 0;
        wid++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit mn = 1'b0, mp = 1'b0, clr_app;
    int prev_id = 0, drops_b = 0, reps_c = 0, slips_a = 0;
    #23;
    check(rd_data == 8'd0, "R1", "reset rd_data", rd_data, 0);
    check(!rd_sof, "R1", "reset rd_sof", rd_sof, 0);
    check(!slip_n && !slip_p, "R1", "reset flags", {slip_n, slip_p}, 0);
    #30 rst_ni = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b1;
    clr   = 1'b1;
    for (int k = 0; k < FRAMES * FL; k++) begin
      int off, fno, id, idx, delta, nf;
      bit ev_n, ev_p;
      string rq;
      clr_app = clr;
      @(negedge rd_clk);
      off = k % FL;
      fno = k / FL;
      ev_n = 1'b0;
      ev_p = 1'b0;
      check(rd_sof == (off == 0), "R3", "rd_sof", rd_sof, off == 0);
      if (fno >= 1) begin
        id  = int'(rd_data[7:5]);
        idx = int'(rd_data[4:0]);
        rq  = (fno < 12 && (id == TRUNC_ID || id == TRUNC_ID + 1)) ? "R9" : "R2";
        check(idx == off, rq, "byte offset", idx, off);
        if (off == 0) begin
          if (fno == 1) begin
            check(id == 0, "R1", "first delivered frame", id, 0);
          end else begin
            delta = (id - prev_id) & 7;
            check(delta <= 2, "R2", "frame step", delta, 1);
            ev_n = (delta == 2);
            ev_p = (delta == 0);
            if (fno < 12) begin
              check(delta == 1, "R4", "equal-rate frame step", delta, 1);
              if (delta != 1) slips_a++;
            end else if (fno < 32 && ev_n) drops_b++;
            else if (fno >= 32 && fno < 52 && ev_p) reps_c++;
          end
          prev_id = id;
        end
      end
      rq = ev_n ? (clr_app ? "R8" : "R5") : ((mn && !clr_app) ? "R7" : "R5");
      mn = ev_n | (mn & !clr_app);
      check(slip_n == mn, rq, "slip_n", slip_n, mn);
      rq = ev_p ? (clr_app ? "R8" : "R6") : ((mp && !clr_app) ? "R7" : "R6");
      mp = ev_p | (mp & !clr_app);
      check(slip_p == mp, rq, "slip_p", slip_p, mp);
      // settings for the next read
      nf = (k + 1) / FL;
      if (nf < 12)      rd_half = 5.0;
      else if (nf < 32) rd_half = 6.0;
      else if (nf < 52) rd_half = 4.0;
      else if (nf < 67) rd_half = 6.0;
      else              rd_half = 5.0;
      if (nf < 52)      clr = 1'b1;
      else              clr = (k + 1 == 70 * FL + 5);
    end
    check(slips_a == 0, "R4", "slips at equal rate", slips_a, 0);
    check(drops_b > 0, "R5", "frames dropped with slow reader", drops_b, 1);
    check(reps_c > 0, "R6", "frames repeated with fast reader", reps_c, 1);
    check(!slip_n && !slip_p, "R7", "flags after clear pulse", {slip_n, slip_p}, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule